// File: doc/BRIEF.md
# Streaming Rectangular Event Clusterer

This block collects pixel events of one frame, delivered one at a time in raster order, into rectangular windows that never overlap. Every event is weighed against the windows already held in a register table. If one window contains the event, nothing changes. If some windows border the event on a side that raster order allows, the best of them grows to cover it. If no window can take the event, the block opens a fresh 1x1 window at that pixel. The block makes one pass per frame and never revisits a decision.

A frame-end strobe makes the block stream out its table, one window per clock in slot order, and then empty the table for the next frame. Growth is limited by a per-axis size cap. A grow is also refused when the enlarged rectangle would intersect any other stored window. When the table is full and a new window is needed, the event is lost and a sticky flag records the loss until the frame has been streamed out.

Top module: `event_clusterer`

## Requirements
- R1: After reset, `ev_ready` is 1, `win_valid` is 0 and `overflow` is 0.
- R2: An event is taken on a clock edge where `ev_valid` and `ev_ready` are both 1. `ev_ready` is then 0 for exactly one cycle while the event is processed.
- R3: An event that no stored window can take opens a new window (x, y, 1, 1) in the next free slot.
- R4: A window with corner (X, Y), width W and height H grows to take event (x, y) in four cases. Right: x = X+W and Y ≤ y < Y+H, width +1. Right-down: x = X+W and y = Y+H, width and height +1. Down: X ≤ x < X+W and y = Y+H, height +1. Left-down: x = X−1 and y = Y+H, corner x −1, width and height +1.
- R5: An event already inside a stored window leaves the table unchanged.
- R6: A grow that would make width or height exceed CAP (8) is refused, so no output window is wider or taller than CAP.
- R7: A grow that would make the enlarged window intersect any other stored window is refused.
- R8: Among the windows that can grow, the one growing right is preferred, then right-down, then down, then left-down. Ties go to the lower slot.
- R9: If a new window is needed while all DEPTH slots are used, the event is dropped and `overflow` rises. It stays high until the end of the frame's window stream and is 0 the cycle after.
- R10: A `frame_end` pulse while the block is idle starts the output. The block streams one window per cycle in slot order (the order of creation), marks the final one with `win_last`, holds `ev_ready` low while streaming, and then empties the table. A frame with no windows streams nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block can take an event |
| ev_x | input | CW | Event column |
| ev_y | input | CW | Event row |
| frame_end | input | 1 | End-of-frame strobe, one cycle |
| win_valid | output | 1 | Window output valid |
| win_last | output | 1 | Final window of the frame |
| win_x | output | CW | Window left column |
| win_y | output | CW | Window top row |
| win_w | output | SW | Window width |
| win_h | output | SW | Window height |
| overflow | output | 1 | Sticky: an event was dropped this frame |

## Verification
The checker watches the cycle-level contracts on every clock: the one-cycle busy window after each accepted event, the unbroken window stream closed by `win_last`, `ev_ready` held low while streaming, the size cap on every emitted window, and the sticky life of `overflow` up to its clearing. What the table ends up holding depends on geometry: which window grows, the overlap veto, the direction preference and the drop on a full table. These show only in the frame scenarios, whose streamed windows the bench compares with its own model of the growth rules.

// File: rtl/clus_pkg.sv
// Shared types for the event clusterer.
// Assumes: the adjacency classes are mutually exclusive for one window.
package clus_pkg;

    typedef enum logic [2:0] {
        ADJ_NONE,
        ADJ_IN,
        ADJ_R,
        ADJ_RD,
        ADJ_D,
        ADJ_LD
    } adj_e;

    // Preference rank of a growth class; lower wins, 7 means not a grow.
    function automatic logic [2:0] grow_rank(adj_e c);
        case (c)
            ADJ_R:   grow_rank = 3'd0;
            ADJ_RD:  grow_rank = 3'd1;
            ADJ_D:   grow_rank = 3'd2;
            ADJ_LD:  grow_rank = 3'd3;
            default: grow_rank = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/clus_adjacent.sv
// Classifies one stored window against the current event and produces
// the rectangle that window would become if it took the event.
// Assumes: sizes are stored in SW bits wide enough to hold CAP+1.
module clus_adjacent
    import clus_pkg::*;
#(
    parameter int CW  = 11,
    parameter int SW  = 4,
    parameter int CAP = 8
) (
    input  logic          slot_used,
    input  logic [CW-1:0] slot_x,
    input  logic [CW-1:0] slot_y,
    input  logic [SW-1:0] slot_w,
    input  logic [SW-1:0] slot_h,
    input  logic [CW-1:0] ev_x,
    input  logic [CW-1:0] ev_y,
    output adj_e          cls,
    output logic [CW-1:0] grown_x,
    output logic [SW-1:0] grown_w,
    output logic [SW-1:0] grown_h,
    output logic          fits
);
    localparam int XW = CW + 1;

    logic [XW-1:0] xs, ys, xe, ye, exe, eye;
    logic in_col, in_row, at_right, at_bot, at_left;

    // Edge arithmetic one bit wider so no edge wraps.
    always_comb begin
        xs  = {1'b0, slot_x};
        ys  = {1'b0, slot_y};
        xe  = xs + XW'(slot_w);
        ye  = ys + XW'(slot_h);
        exe = {1'b0, ev_x};
        eye = {1'b0, ev_y};
        in_col   = (exe >= xs) && (exe < xe);
        in_row   = (eye >= ys) && (eye < ye);
        at_right = (exe == xe);
        at_bot   = (eye == ye);
        at_left  = ((exe + XW'(1)) == xs);
    end

    // Class of this window relative to the event.
    always_comb begin
        if (!slot_used)                 cls = ADJ_NONE;
        else if (in_col && in_row)      cls = ADJ_IN;
        else if (at_right && in_row)    cls = ADJ_R;
        else if (at_right && at_bot)    cls = ADJ_RD;
        else if (in_col && at_bot)      cls = ADJ_D;
        else if (at_left && at_bot)     cls = ADJ_LD;
        else                            cls = ADJ_NONE;
    end

    // Enlarged rectangle and its size-cap test.
    always_comb begin
        grown_x = (cls == ADJ_LD) ? slot_x - CW'(1) : slot_x;
        grown_w = slot_w + SW'((cls == ADJ_R || cls == ADJ_RD || cls == ADJ_LD) ? 1 : 0);
        grown_h = slot_h + SW'((cls == ADJ_RD || cls == ADJ_D || cls == ADJ_LD) ? 1 : 0);
        fits    = (grown_w <= SW'(CAP)) && (grown_h <= SW'(CAP));
    end
endmodule

// File: rtl/clus_overlap.sv
// Tests whether a proposed rectangle for slot SELF intersects any other
// used slot of the table.
// Assumes: the proposed corner y equals the stored one (growth never moves up).
module clus_overlap #(
    parameter int CW    = 11,
    parameter int SW    = 4,
    parameter int DEPTH = 16,
    parameter int SELF  = 0
) (
    input  logic [CW-1:0] prop_x,
    input  logic [CW-1:0] prop_y,
    input  logic [SW-1:0] prop_w,
    input  logic [SW-1:0] prop_h,
    input  logic [CW-1:0] tab_x [DEPTH],
    input  logic [CW-1:0] tab_y [DEPTH],
    input  logic [SW-1:0] tab_w [DEPTH],
    input  logic [SW-1:0] tab_h [DEPTH],
    input  logic [DEPTH-1:0] used,
    output logic          hit
);
    localparam int XW = CW + 1;

    logic [XW-1:0] px0, py0, px1, py1;

    // Interval intersection on both axes against every other slot.
    always_comb begin
        px0 = {1'b0, prop_x};
        py0 = {1'b0, prop_y};
        px1 = px0 + XW'(prop_w);
        py1 = py0 + XW'(prop_h);
        hit = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (j != SELF && used[j]) begin
                if (px0 < ({1'b0, tab_x[j]} + XW'(tab_w[j])) && {1'b0, tab_x[j]} < px1 &&
                    py0 < ({1'b0, tab_y[j]} + XW'(tab_h[j])) && {1'b0, tab_y[j]} < py1)
                    hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/clus_pick.sv
// Chooses the window that takes the event: containment first, then the
// best growth class, ties to the lowest slot.
// Assumes: ok[i] is set only for a legal growth class of slot i.
module clus_pick
    import clus_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  adj_e             cls [DEPTH],
    input  logic [DEPTH-1:0] ok,
    output logic             absorbed,
    output logic             grow_hit,
    output logic [AW-1:0]    grow_idx
);
    logic [2:0] best;

    // Priority scan over all slots.
    always_comb begin
        absorbed = 1'b0;
        grow_hit = 1'b0;
        grow_idx = '0;
        best     = 3'd7;
        for (int i = 0; i < DEPTH; i++) begin
            if (cls[i] == ADJ_IN) absorbed = 1'b1;
            if (ok[i] && grow_rank(cls[i]) < best) begin
                best     = grow_rank(cls[i]);
                grow_idx = AW'(i);
                grow_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/event_clusterer.sv
// Single-pass clusterer: raster-ordered events grow or open rectangular
// windows in a register table; frame_end streams the table out and clears it.
// Assumes: events of one frame arrive in raster order; frame_end is a
// one-cycle pulse; the output consumer always accepts.
module event_clusterer
    import clus_pkg::*;
#(
    parameter int CW    = 11,
    parameter int DEPTH = 16,
    parameter int CAP   = 8,
    localparam int SW   = $clog2(CAP + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    output logic          ev_ready,
    input  logic [CW-1:0] ev_x,
    input  logic [CW-1:0] ev_y,
    input  logic          frame_end,
    output logic          win_valid,
    output logic          win_last,
    output logic [CW-1:0] win_x,
    output logic [CW-1:0] win_y,
    output logic [SW-1:0] win_w,
    output logic [SW-1:0] win_h,
    output logic          overflow
);
    localparam int IW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef enum logic [1:0] {ST_IDLE, ST_PROC, ST_DRAIN} state_e;

    state_e        state;
    logic [CW-1:0] tx [DEPTH];
    logic [CW-1:0] ty [DEPTH];
    logic [SW-1:0] tw [DEPTH];
    logic [SW-1:0] th [DEPTH];
    logic [IW-1:0] count;
    logic [AW-1:0] drain_idx;
    logic [CW-1:0] cur_x, cur_y;

    adj_e          cls [DEPTH];
    logic [CW-1:0] gx  [DEPTH];
    logic [SW-1:0] gw  [DEPTH];
    logic [SW-1:0] gh  [DEPTH];
    logic [DEPTH-1:0] used, fits, hit, ok;
    logic          absorbed, grow_hit;
    logic [AW-1:0] grow_idx;

    // One classifier and one overlap tester per table slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign used[g] = (IW'(g) < count);

        clus_adjacent #(.CW(CW), .SW(SW), .CAP(CAP)) u_adj (
            .slot_used(used[g]), .slot_x(tx[g]), .slot_y(ty[g]),
            .slot_w(tw[g]), .slot_h(th[g]), .ev_x(cur_x), .ev_y(cur_y),
            .cls(cls[g]), .grown_x(gx[g]), .grown_w(gw[g]), .grown_h(gh[g]),
            .fits(fits[g])
        );

        clus_overlap #(.CW(CW), .SW(SW), .DEPTH(DEPTH), .SELF(g)) u_ovl (
            .prop_x(gx[g]), .prop_y(ty[g]), .prop_w(gw[g]), .prop_h(gh[g]),
            .tab_x(tx), .tab_y(ty), .tab_w(tw), .tab_h(th),
            .used(used), .hit(hit[g])
        );

        assign ok[g] = fits[g] && !hit[g] &&
                       (cls[g] == ADJ_R || cls[g] == ADJ_RD ||
                        cls[g] == ADJ_D || cls[g] == ADJ_LD);
    end

    clus_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
        .cls(cls), .ok(ok), .absorbed(absorbed),
        .grow_hit(grow_hit), .grow_idx(grow_idx)
    );

    // Handshake and output stream decode.
    always_comb begin
        ev_ready  = (state == ST_IDLE) && !frame_end;
        win_valid = (state == ST_DRAIN);
        win_last  = win_valid && ((IW'(drain_idx) + IW'(1)) == count);
        win_x     = tx[drain_idx];
        win_y     = ty[drain_idx];
        win_w     = tw[drain_idx];
        win_h     = th[drain_idx];
    end

    // Control sequence and table update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            count     <= '0;
            overflow  <= 1'b0;
            drain_idx <= '0;
            cur_x     <= '0;
            cur_y     <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tx[i] <= '0;
                ty[i] <= '0;
                tw[i] <= '0;
                th[i] <= '0;
            end
        end else begin
            case (state)
                ST_IDLE: begin
                    if (frame_end) begin
                        drain_idx <= '0;
                        if (count == '0) overflow <= 1'b0;
                        else             state    <= ST_DRAIN;
                    end else if (ev_valid) begin
                        cur_x <= ev_x;
                        cur_y <= ev_y;
                        state <= ST_PROC;
                    end
                end
                ST_PROC: begin
                    state <= ST_IDLE;
                    if (!absorbed) begin
                        if (grow_hit) begin
                            tx[grow_idx] <= gx[grow_idx];
                            tw[grow_idx] <= gw[grow_idx];
                            th[grow_idx] <= gh[grow_idx];
                        end else if (count < IW'(DEPTH)) begin
                            tx[count[AW-1:0]] <= cur_x;
                            ty[count[AW-1:0]] <= cur_y;
                            tw[count[AW-1:0]] <= SW'(1);
                            th[count[AW-1:0]] <= SW'(1);
                            count <= count + IW'(1);
                        end else begin
                            overflow <= 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (win_last) begin
                        count    <= '0;
                        overflow <= 1'b0;
                        state    <= ST_IDLE;
                    end else begin
                        drain_idx <= drain_idx + AW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clus_checker.sv
// Cycle-level protocol and bound checks for event_clusterer, seen only
// through its ports.
module clus_checker #(
    parameter int CW  = 11,
    parameter int SW  = 4,
    parameter int CAP = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_valid,
    input logic          ev_ready,
    input logic          frame_end,
    input logic          win_valid,
    input logic          win_last,
    input logic [SW-1:0] win_w,
    input logic [SW-1:0] win_h,
    input logic          overflow
);
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready);

    assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |-> ##2 (ev_ready || frame_end));

    assert_size_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_w >= SW'(1) && win_w <= SW'(CAP) &&
                       win_h >= SW'(1) && win_h <= SW'(CAP)));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !win_last) |=> overflow);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> !overflow);

    assert_stream_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !ev_ready);

    assert_stream_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_last) |=> win_valid);

    assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |-> win_valid);
endmodule

bind event_clusterer clus_checker #(.CW(CW), .SW(SW), .CAP(CAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .frame_end(frame_end), .win_valid(win_valid), .win_last(win_last),
    .win_w(win_w), .win_h(win_h), .overflow(overflow)
);

// File: tb/event_clusterer_bench.sv
`timescale 1ns/1ps
module event_clusterer_bench;
    localparam int CW    = 11;
    localparam int DEPTH = 16;
    localparam int CAP   = 8;
    localparam int SW    = $clog2(CAP + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [CW-1:0] ev_x = '0;
    logic [CW-1:0] ev_y = '0;
    logic          frame_end = 1'b0;
    logic          win_valid, win_last, overflow;
    logic [CW-1:0] win_x, win_y;
    logic [SW-1:0] win_w, win_h;

    int n_vec = 0;
    int n_bad = 0;

    int mx [DEPTH];
    int my [DEPTH];
    int mw [DEPTH];
    int mh [DEPTH];
    int mcount = 0;
    bit movf = 0;

    always #4 clk = ~clk;

    event_clusterer #(.CW(CW), .DEPTH(DEPTH), .CAP(CAP)) u_event_clusterer (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_x(ev_x), .ev_y(ev_y), .frame_end(frame_end),
        .win_valid(win_valid), .win_last(win_last), .win_x(win_x),
        .win_y(win_y), .win_w(win_w), .win_h(win_h), .overflow(overflow)
    );

    task automatic chk(bit good, string req, int act, int exp);
        n_vec++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference growth rules: R3, R4, R5, R6, R7, R8, R9.
    function automatic void model_event(int x, int y);
        int best = -1;
        int brank = 9;
        int bx = 0, bw = 0, bh = 0;
        bit absorb = 0;
        for (int i = 0; i < mcount; i++) begin
            int nx, nw, nh, rk;
            bit incol, inrow, ov;
            nx = mx[i]; nw = mw[i]; nh = mh[i]; rk = 9; ov = 0;
            incol = (x >= mx[i]) && (x < mx[i] + mw[i]);
            inrow = (y >= my[i]) && (y < my[i] + mh[i]);
            if (incol && inrow) absorb = 1;
            else if (x == mx[i] + mw[i] && inrow) begin rk = 0; nw++; end
            else if (x == mx[i] + mw[i] && y == my[i] + mh[i]) begin rk = 1; nw++; nh++; end
            else if (incol && y == my[i] + mh[i]) begin rk = 2; nh++; end
            else if (x == mx[i] - 1 && y == my[i] + mh[i]) begin rk = 3; nx--; nw++; nh++; end
            if (rk < 9 && nw <= CAP && nh <= CAP) begin
                for (int j = 0; j < mcount; j++)
                    if (j != i && nx < mx[j] + mw[j] && mx[j] < nx + nw &&
                        my[i] < my[j] + mh[j] && my[j] < my[i] + nh) ov = 1;
                if (!ov && rk < brank) begin
                    brank = rk; best = i; bx = nx; bw = nw; bh = nh;
                end
            end
        end
        if (absorb) return;
        if (best >= 0) begin
            mx[best] = bx; mw[best] = bw; mh[best] = bh;
        end else if (mcount < DEPTH) begin
            mx[mcount] = x; my[mcount] = y; mw[mcount] = 1; mh[mcount] = 1;
            mcount++;
        end else begin
            movf = 1;
        end
    endfunction

    // Offer one event; check the one-cycle busy period (R2).
    task automatic send_ev(int x, int y);
        while (!ev_ready) @(negedge clk);
        ev_valid = 1'b1;
        ev_x = CW'(x);
        ev_y = CW'(y);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(ev_ready == 1'b0, "R2 busy after accept", ev_ready, 0);
        model_event(x, y);
        @(negedge clk);
        chk(ev_ready == 1'b1, "R2 ready again", ev_ready, 1);
    endtask

    // Close the frame and compare the window stream (R10 plus scenario tag).
    task automatic end_frame(string req);
        int got = 0;
        bit done = 0;
        chk(overflow == movf, {req, " R9 overflow before frame end"}, overflow, movf);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        for (int c = 0; c < DEPTH + 4 && !done; c++) begin
            if (win_valid) begin
                if (got < mcount) begin
                    chk(win_x == CW'(mx[got]), {req, " win_x"}, win_x, mx[got]);
                    chk(win_y == CW'(my[got]), {req, " win_y"}, win_y, my[got]);
                    chk(win_w == SW'(mw[got]), {req, " win_w"}, win_w, mw[got]);
                    chk(win_h == SW'(mh[got]), {req, " win_h"}, win_h, mh[got]);
                end
                chk(win_last == (got == mcount - 1), "R10 last marker", win_last, got == mcount - 1);
                chk(ev_ready == 1'b0, "R10 ready low while streaming", ev_ready, 0);
                got++;
                if (win_last) done = 1;
            end
            @(negedge clk);
        end
        chk(got == mcount, {req, " R10 window count"}, got, mcount);
        chk(overflow == 1'b0, "R9 flag cleared after stream", overflow, 0);
        chk(ev_ready == 1'b1, "R10 idle after stream", ev_ready, 1);
        mcount = 0;
        movf = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (R10 progress)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ev_ready == 1'b1, "R1 ready after reset", ev_ready, 1);
        chk(win_valid == 1'b0, "R1 no output after reset", win_valid, 0);
        chk(overflow == 1'b0, "R1 overflow low after reset", overflow, 0);

        // R3: a lone event opens a 1x1 window.
        send_ev(5, 5);
        chk(mcount == 1, "R3 model one window", mcount, 1);
        end_frame("R3");

        // R5: a repeated event is absorbed.
        send_ev(7, 3);
        send_ev(7, 3);
        end_frame("R5");

        // R4: right, down, left-down, right-down growth into one window.
        send_ev(2, 1); send_ev(3, 1); send_ev(4, 1);
        send_ev(2, 2);
        send_ev(1, 3);
        send_ev(5, 4);
        chk(mcount == 1 && mx[0] == 1 && mw[0] == 5 && mh[0] == 4,
            "R4 model chain", mw[0] * 10 + mh[0], 54);
        end_frame("R4");

        // R6: a row of ten splits at the cap of eight.
        for (int k = 0; k < 10; k++) send_ev(k, 0);
        chk(mcount == 2 && mw[0] == 8 && mw[1] == 2, "R6 model split", mw[0], 8);
        end_frame("R6");

        // R8 then R7: right-down preferred over left-down; right vetoed by overlap.
        send_ev(0, 0); send_ev(2, 0); send_ev(1, 1); send_ev(2, 1);
        chk(mw[0] == 2 && mh[0] == 2 && mh[1] == 2, "R8 R7 model result", mh[1], 2);
        end_frame("R8 R7");

        // R10: empty frame streams nothing.
        end_frame("R10 empty");

        // R9: more isolated events than slots.
        for (int k = 0; k < DEPTH + 3; k++) send_ev(2 * (k % 8), 2 * (k / 8));
        chk(movf == 1, "R9 model overflow", movf, 1);
        end_frame("R9");

        // Random raster frames of varying density, all requirements.
        for (int f = 0; f < 14; f++) begin
            int ox, oy, dens;
            ox = $urandom_range(0, 40);
            oy = $urandom_range(0, 40);
            dens = (f % 3 == 0) ? 15 : ((f % 3 == 1) ? 40 : 70);
            for (int y = 0; y < 12; y++)
                for (int x = 0; x < 18; x++)
                    if ($urandom_range(0, 99) < dens) begin
                        send_ev(ox + x, oy + y);
                        if ($urandom_range(0, 19) == 0) send_ev(ox + x, oy + y);
                    end
            end_frame("R4 R6 R7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule